// File: doc/BRIEF.md
# ADC serial control and readout interface

This block is the serial slave port of a data converter. A host lowers chip select and clocks one 16-bit word through it. Its control word goes in on the data input while the latest conversion result comes back on the data output, first bit first. Shifting is fully static: the serial clock may stop at any point in a word, so a host that moves bytes can send the word as two 8-bit bursts with any pause between them, as long as chip select stays low for the whole exchange. A single 16-clock burst also works.

The first bit of the incoming word decides what happens when chip select rises. If that bit is 1 and exactly 16 clocks arrived, the other 15 bits are written into a control register and a conversion starts. Otherwise the word is dropped. The control register drives the converter settings through a plain output bus. A small sequencer holds busy high for a fixed number of system clocks, then latches sign, overflow and magnitude from a parallel result port. That latched word is loaded into the output shift register only while chip select is high. All serial pins pass through synchronizers into the system clock domain.

Top module: `adc_serial_if`

## Requirements
- R1: After reset, cfg is 0, busy is 0 and sdo is 0 (the stored result word is 0).
- R2: A word of exactly 16 rising sclk edges with its first bit equal to 1 sets cfg to the word's remaining 15 bits, MSB first, within 3 system clocks after cs_n rises. This holds across a sweep of walking-one and walking-zero settings.
- R3: A 16-bit word whose first bit is 0 leaves cfg unchanged and starts no conversion (busy stays 0).
- R4: If cs_n rises after 15 or 17 rising sclk edges, the word is discarded: cfg is unchanged and busy stays 0.
- R5: A committed word raises busy 3 system clocks after cs_n rises. Busy then stays high for exactly CONV_CYC system clocks, unless a new commit arrives.
- R6: When a conversion ends, {res_sign, res_ovf, res_mag} is latched. The next transfer returns it on sdo in the order sign, overflow, then magnitude MSB to LSB. The first bit is valid after cs_n falls and before the first sclk edge.
- R7: While cs_n is low, sdo changes only after falling sclk edges. A conversion that ends during a transfer does not alter that transfer's bits. The new result appears in the next transfer.
- R8: A commit during busy restarts the conversion: busy stays high until CONV_CYC clocks after the new commit and the aborted result is not latched. A commit that lands in the same clock as the natural end of a conversion also wins, so busy stays high.
- R9: A word delivered as two 8-bit bursts, with a long pause of sclk held low between them and cs_n held low, commits and reads the same as a continuous burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous to clk |
| sclk | input | 1 | Serial clock, idle low; data sampled on the rising edge |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host; changes after falling sclk edges |
| busy | output | 1 | High while a conversion is in progress |
| cfg | output | MAG_W+1 | Control register (converter settings) |
| res_sign | input | 1 | Result polarity from converter |
| res_ovf | input | 1 | Result overflow from converter |
| res_mag | input | MAG_W | Result magnitude from converter |

## Verification
The end of a running conversion and the start of a new commit can fall in the same system clock. In that clock the design must restart rather than latch a result. The bench provokes this by timing a second commit's chip-select release at offsets of CONV_CYC-2 to CONV_CYC+2 clocks after the first. Each offset is judged by whether busy is still high at the first conversion's end clock. A readout taken between the two conversions must return either the previous result or the first conversion's result, as the offset predicts. The bench also shows that a result latched in the middle of a transfer stays out of that transfer's bits.

// File: rtl/adc_sif_pkg.sv
package adc_sif_pkg;

    // Bundle of the asynchronous serial pins, carried through the synchronizer.
    typedef struct packed {
        logic cs_n;
        logic sclk;
        logic sdi;
    } serial_pins_t;

    localparam int PIN_W = $bits(serial_pins_t);

    // Pin values when the host is idle; also the synchronizer reset value.
    localparam serial_pins_t PINS_IDLE = '{cs_n: 1'b1, sclk: 1'b0, sdi: 1'b0};

    // Conversion sequencer states.
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;

endpackage

// File: rtl/adc_sif_sync.sv
module adc_sif_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            stg_d[s] = stg_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stg_q[s] <= RST_VAL;
            end
        end else begin
            stg_q <= stg_d;
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/adc_sif_shift.sv
module adc_sif_shift #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sclk_s,
    input  logic              sdi_s,
    input  logic [WORD_W-1:0] load_word,
    output logic              sdo,
    output logic              cs_low,
    output logic              sclk_fall,
    output logic              commit,
    output logic [WORD_W-2:0] cmd
);

    localparam int CNT_W = $clog2(WORD_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

    typedef struct packed {
        logic [WORD_W-1:0] rx;
        logic [WORD_W-1:0] tx;
        logic [CNT_W-1:0]  cnt;
        logic              cs_p;
        logic              sclk_p;
    } shift_st_t;

    shift_st_t st_d, st_q;
    logic      cs_rise;
    logic      sclk_rise;

    always_comb begin
        st_d        = st_q;
        st_d.cs_p   = cs_n_s;
        st_d.sclk_p = sclk_s;

        cs_rise   = cs_n_s & ~st_q.cs_p;
        sclk_rise = ~cs_n_s & sclk_s & ~st_q.sclk_p;
        sclk_fall = ~cs_n_s & ~sclk_s & st_q.sclk_p;

        if (cs_n_s) begin
            // Idle: keep the outgoing word refreshed, restart the count.
            st_d.tx  = load_word;
            st_d.cnt = '0;
        end else begin
            if (sclk_rise) begin
                st_d.rx = {st_q.rx[WORD_W-2:0], sdi_s};
                if (st_q.cnt != CNT_SAT) begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
            if (sclk_fall) begin
                st_d.tx = {st_q.tx[WORD_W-2:0], 1'b0};
            end
        end

        commit = cs_rise && (st_q.cnt == CNT_FULL) && st_q.rx[WORD_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.rx     <= '0;
            st_q.tx     <= '0;
            st_q.cnt    <= '0;
            st_q.cs_p   <= 1'b1;
            st_q.sclk_p <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdo    = st_q.tx[WORD_W-1];
    assign cs_low = ~cs_n_s;
    assign cmd    = st_q.rx[WORD_W-2:0];

endmodule

// File: rtl/adc_sif_seq.sv
module adc_sif_seq
    import adc_sif_pkg::*;
#(
    parameter int WORD_W   = 16,
    parameter int CONV_CYC = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              res_sign,
    input  logic              res_ovf,
    input  logic [WORD_W-3:0] res_mag,
    output logic              busy,
    output logic [WORD_W-1:0] result
);

    localparam int CCW = (CONV_CYC > 1) ? $clog2(CONV_CYC) : 1;
    localparam logic [CCW-1:0] CNT_LAST = CCW'(CONV_CYC - 1);

    typedef struct packed {
        seq_state_t        state;
        logic [CCW-1:0]    cnt;
        logic [WORD_W-1:0] res;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            // A new commit always wins, also over a conversion ending now.
            st_d.state = SEQ_RUN;
            st_d.cnt   = '0;
        end else if (st_q.state == SEQ_RUN) begin
            if (st_q.cnt == CNT_LAST) begin
                st_d.state = SEQ_IDLE;
                st_d.res   = {res_sign, res_ovf, res_mag};
            end else begin
                st_d.cnt = st_q.cnt + CCW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state <= SEQ_IDLE;
            st_q.cnt   <= '0;
            st_q.res   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy   = (st_q.state == SEQ_RUN);
    assign result = st_q.res;

endmodule

// File: rtl/adc_serial_if.sv
module adc_serial_if
    import adc_sif_pkg::*;
#(
    parameter int MAG_W       = 14,
    parameter int CONV_CYC    = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             sdi,
    output logic             sdo,
    output logic             busy,
    output logic [MAG_W:0]   cfg,
    input  logic             res_sign,
    input  logic             res_ovf,
    input  logic [MAG_W-1:0] res_mag
);

    localparam int WORD_W = MAG_W + 2;
    localparam int CFG_W  = WORD_W - 1;

    serial_pins_t           pins_raw, pins_s;
    logic [PIN_W-1:0]       pins_s_vec;
    logic                   commit_w;
    logic                   cs_low_w;
    logic                   sclk_fall_w;
    logic [CFG_W-1:0]       cmd_w;
    logic [WORD_W-1:0]      result_w;
    logic [CFG_W-1:0]       cfg_d, cfg_q;

    assign pins_raw = '{cs_n: cs_n, sclk: sclk, sdi: sdi};

    adc_sif_sync #(
        .W      (PIN_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PINS_IDLE)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pins_raw),
        .dout (pins_s_vec)
    );

    assign pins_s = serial_pins_t'(pins_s_vec);

    adc_sif_shift #(
        .WORD_W(WORD_W)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_s   (pins_s.cs_n),
        .sclk_s   (pins_s.sclk),
        .sdi_s    (pins_s.sdi),
        .load_word(result_w),
        .sdo      (sdo),
        .cs_low   (cs_low_w),
        .sclk_fall(sclk_fall_w),
        .commit   (commit_w),
        .cmd      (cmd_w)
    );

    adc_sif_seq #(
        .WORD_W  (WORD_W),
        .CONV_CYC(CONV_CYC)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (commit_w),
        .res_sign(res_sign),
        .res_ovf (res_ovf),
        .res_mag (res_mag),
        .busy    (busy),
        .result  (result_w)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (commit_w) begin
            cfg_d = cmd_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/adc_sif_chk.sv
module adc_sif_chk #(
    parameter int CFG_W    = 15,
    parameter int CONV_CYC = 256
) (
    input logic             clk,
    input logic             rst_n,
    input logic             commit,
    input logic             cs_low,
    input logic             sclk_fall,
    input logic             busy,
    input logic             sdo,
    input logic [CFG_W-1:0] cfg
);

    // Busy cycles since the most recent commit.
    logic [31:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (commit) begin
            run_q <= 32'd1;
        end else if (busy) begin
            run_q <= run_q + 32'd1;
        end
    end

    // R3 R4
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(cfg));

    // R5
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> busy);

    // R5
    busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_q <= 32'(CONV_CYC)));

    // R8
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(run_q) == 32'(CONV_CYC)));

    // R7
    frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_low && !sclk_fall) |=> $stable(sdo));

endmodule

bind adc_serial_if adc_sif_chk #(
    .CFG_W   (CFG_W),
    .CONV_CYC(CONV_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .commit   (commit_w),
    .cs_low   (cs_low_w),
    .sclk_fall(sclk_fall_w),
    .busy     (busy),
    .sdo      (sdo),
    .cfg      (cfg)
);

// File: tb/adc_serial_if_tb.sv
`timescale 1ns/1ps
module adc_serial_if_tb;

    localparam int MAG_W = 14;
    localparam int CONV  = 180;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic [15:0] res_w = 16'h0;
    logic        sdo;
    logic        busy;
    logic [14:0] cfg;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    bit finished = 0;

    logic [14:0] exp_cfg;
    logic [15:0] exp_res;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    adc_serial_if #(
        .MAG_W      (MAG_W),
        .CONV_CYC   (CONV),
        .SYNC_STAGES(2)
    ) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .sclk    (sclk),
        .sdi     (sdi),
        .sdo     (sdo),
        .busy    (busy),
        .cfg     (cfg),
        .res_sign(res_w[15]),
        .res_ovf (res_w[14]),
        .res_mag (res_w[13:0])
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Lower cs_n and clock out n bits (MSB of the n-bit field first),
    // sampling sdo before each rising edge. cs_n stays low afterwards.
    task automatic shift_bits(input logic [31:0] bits, input int n,
                              input int pause_after, input int pause_len,
                              output logic [15:0] rd);
        rd = '0;
        cs_n = 1'b0;
        tick(4);
        for (int i = 0; i < n; i++) begin
            sdi = bits[n-1-i];
            tick(4);
            if (i < 16) rd[15-i] = sdo;
            sclk = 1'b1;
            tick(4);
            sclk = 1'b0;
            if (i + 1 == pause_after) tick(pause_len);
        end
        tick(4);
    endtask

    task automatic release_cs(output int c);
        c = cyc;
        cs_n = 1'b1;
    endtask

    task automatic xfer16(input logic [15:0] w, output logic [15:0] rd, output int c);
        shift_bits({16'h0, w}, 16, 0, 0, rd);
        release_cs(c);
        tick(6);
    endtask

    function automatic logic [15:0] pat_a(input int k);
        return {1'b1, 1'b0, 14'((k * 37 + 5) % 16384)};
    endfunction

    function automatic logic [15:0] pat_b(input int k);
        return {1'b0, 1'b1, 14'((k * 91 + 3) % 16384)};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        logic [15:0] prev_res;
        logic [14:0] x;
        int c, c0, c1;

        tick(5);
        rst_n = 1'b1;
        tick(2);
        // R1
        chk("R1 cfg", {17'h0, cfg}, 32'h0);
        chk("R1 busy", {31'h0, busy}, 32'h0);
        chk("R1 sdo", {31'h0, sdo}, 32'h0);
        exp_cfg = '0;
        exp_res = '0;

        // R2: walking ones and zeros over the 15 control bits
        res_w = 16'hA5C3;
        for (int k = 0; k < 30; k++) begin
            x = (k < 15) ? 15'(1 << k) : ~15'(1 << (k - 15));
            xfer16({1'b1, x}, rd, c);
            chk("R2 cfg", {17'h0, cfg}, {17'h0, x});
            chk("R5 busy raised", {31'h0, busy}, 32'h1);
            chk("R8 no result from restarted conversion", {16'h0, rd}, {16'h0, exp_res});
            exp_cfg = x;
        end

        // R5: exact busy length after the last commit
        wait_until(c + 3 + CONV - 1);
        chk("R5 busy last cycle", {31'h0, busy}, 32'h1);
        wait_until(c + 3 + CONV);
        chk("R5 busy fallen", {31'h0, busy}, 32'h0);
        exp_res = res_w;
        tick(4);

        // R3: uncommitted word, also reads the result (R6)
        xfer16(16'h7FFF, rd, c);
        chk("R6 read after conversion", {16'h0, rd}, {16'h0, exp_res});
        chk("R3 cfg held", {17'h0, cfg}, {17'h0, exp_cfg});
        chk("R3 no busy", {31'h0, busy}, 32'h0);
        tick(20);
        chk("R3 no busy later", {31'h0, busy}, 32'h0);

        // R6: result sweep
        for (int p = 0; p < 8; p++) begin
            res_w = {p[0], p[1], 14'((p * 1234 + 77) % 16384)};
            x = 15'h4000 | 15'(p);
            xfer16({1'b1, x}, rd, c);
            exp_cfg = x;
            chk("R2 cfg sweep", {17'h0, cfg}, {17'h0, exp_cfg});
            wait_until(c + 3 + CONV + 2);
            chk("R5 idle after conversion", {31'h0, busy}, 32'h0);
            exp_res = res_w;
            xfer16(16'h0000, rd, c);
            chk("R6 result order", {16'h0, rd}, {16'h0, exp_res});
        end

        // R4: 15-bit word discarded
        shift_bits({17'h0, 15'h7ABC}, 15, 0, 0, rd);
        release_cs(c);
        tick(10);
        chk("R4 short word cfg", {17'h0, cfg}, {17'h0, exp_cfg});
        chk("R4 short word busy", {31'h0, busy}, 32'h0);
        // R4: 17-bit word discarded (last 16 bits form a valid commit)
        shift_bits({15'h0, 1'b0, 16'h9234}, 17, 0, 0, rd);
        release_cs(c);
        tick(10);
        chk("R4 long word cfg", {17'h0, cfg}, {17'h0, exp_cfg});
        chk("R4 long word busy", {31'h0, busy}, 32'h0);

        // R9: split into two bytes with a long pause
        shift_bits({16'h0, 16'hDA5A}, 16, 8, 700, rd);
        release_cs(c);
        tick(6);
        chk("R9 split read", {16'h0, rd}, {16'h0, exp_res});
        chk("R9 split cfg", {17'h0, cfg}, 32'h00005A5A);
        exp_cfg = 15'h5A5A;
        chk("R9 split busy", {31'h0, busy}, 32'h1);
        wait_until(c + 3 + CONV + 2);
        exp_res = res_w;

        // R7: conversion ends mid-transfer
        res_w = 16'h3C96;
        xfer16(16'h8001, rd, c0);
        exp_cfg = 15'h0001;
        wait_until(c0 + 3 + CONV - 60);
        shift_bits(32'h0, 16, 0, 0, rd);
        release_cs(c);
        tick(6);
        chk("R7 old result during transfer", {16'h0, rd}, {16'h0, exp_res});
        exp_res = 16'h3C96;
        xfer16(16'h0000, rd, c);
        chk("R7 new result next transfer", {16'h0, rd}, {16'h0, exp_res});

        // R8: second commit around the end of the first conversion
        for (int d = CONV - 2; d <= CONV + 2; d++) begin
            prev_res = exp_res;
            res_w = pat_a(d);
            xfer16(16'h8100, rd, c0);
            shift_bits({16'h0, 16'h8200 | 16'(d)}, 16, 0, 0, rd);
            wait_until(c0 + d);
            release_cs(c1);
            wait_until(c0 + 3 + CONV);
            chk("R8 busy at first end", {31'h0, busy}, (d <= CONV) ? 32'h1 : 32'h0);
            wait_until(c0 + 3 + CONV + 1);
            res_w = pat_b(d);
            wait_until(c0 + 3 + CONV + 5);
            xfer16(16'h0000, rd, c);
            chk("R8 aborted result not latched", {16'h0, rd},
                {16'h0, (d <= CONV) ? prev_res : pat_a(d)});
            chk("R8 cfg from second commit", {17'h0, cfg}, {17'h0, 15'h0200 | 15'(d)});
            wait_until(c1 + 3 + CONV - 1);
            chk("R8 busy until restart end", {31'h0, busy}, 32'h1);
            wait_until(c1 + 3 + CONV);
            chk("R8 busy falls after restart", {31'h0, busy}, 32'h0);
            tick(3);
            exp_res = pat_b(d);
            xfer16(16'h0000, rd, c);
            chk("R8 restarted result", {16'h0, rd}, {16'h0, exp_res});
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule